// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block configures a target FPGA over a one-bit serial configuration port. Software or a DMA engine pulses `start_i` with the total byte count. It then streams the configuration bytes over a valid/ready interface. The block takes care of the whole target-side protocol:

- It pulls the target's clear line low and waits for the target to report, on its status line, that its configuration memory is being cleared.
- It releases the clear line and waits for the status line to return high.
- It shifts every byte out one bit at a time on a divided serial clock.
- Before each byte, it checks for a target-reported integrity error.
- After the data it keeps clocking with the data line held high until the target signals that it is running.

Every wait on the target is bounded by a cycle-count timeout. The result is reported as a small status code, which holds until the next start. One-cycle strobes before and after the load let surrounding logic prepare the board and clean up. The post-load strobe fires whatever the outcome.

Top module: `sercfg_loader`

## Requirements
- R1: A `start_i` pulse seen while idle drives `tgt_clear_n_o` low from the next cycle, and `pre_hook_o` pulses for that one cycle. The clear line stays low until `tgt_busy_n_i` is seen low, or until the wait times out.
- R2: After the clear line is released, no serial clock edge occurs and no byte is accepted until `tgt_busy_n_i` is seen high.
- R3: Each of the three waits is abandoned after `TIMEOUT_CYC` cycles. The two waits (for `tgt_busy_n_i` low, then high) end with status 3. The final wait for `tgt_live_i` ends with status 5.
- R4: Each accepted byte produces exactly `DATA_W` rising edges on `ser_clk_o`, most significant bit first.
- R5: Each serial clock half-period lasts `CCLK_DIV` system cycles within a byte. `ser_dat_o` changes only while `ser_clk_o` is low, so it is stable across every rising edge.
- R6: Before each byte, if `tgt_busy_n_i` is low while `tgt_live_i` is low, the load ends at once with status 4. No further byte is accepted and no further clock edge is produced.
- R7: After the last byte, `ser_dat_o` is held high and `ser_clk_o` keeps toggling. When `tgt_live_i` is seen high, the load ends with status 2.
- R8: `post_hook_o` pulses for exactly one cycle, on the cycle the final status appears, for every outcome. It is never high together with `pre_hook_o`.
- R9: `status_o` reads 0 after reset, 1 during a load, and then 2 (success), 3 (status-line timeout), 4 (integrity error) or 5 (running-signal timeout). A final code holds until the next accepted start.
- R10: `s_ready_o` is low while a byte is being shifted. The next byte is accepted only between bytes.
- R11: A `start_i` pulse during a load is ignored: no second pre-load strobe, and the byte count is not reloaded.
- R12: A byte count of zero goes straight to the final clocking phase and can still end with status 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a load |
| byte_count_i | input | CNT_W | Number of bytes in the load, sampled with `start_i` |
| s_data_i | input | DATA_W | Stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Block can take a byte this cycle |
| tgt_clear_n_o | output | 1 | Active-low clear request to the target |
| ser_clk_o | output | 1 | Serial configuration clock, target samples on rising edge |
| ser_dat_o | output | 1 | Serial configuration data |
| tgt_busy_n_i | input | 1 | Target status line, low while clearing or on error |
| tgt_live_i | input | 1 | Target signals configuration complete |
| pre_hook_o | output | 1 | One-cycle strobe when a load begins |
| post_hook_o | output | 1 | One-cycle strobe when a load ends |
| status_o | output | 3 | Load status code |

## Verification
The embedded assertions watch, on every cycle, the invariants that are local in time:
- data holding still across the high half of the serial clock;
- no clock or stream acceptance while the clear line is low;
- the two strobes never overlapping, and the post strobe always carrying a final code;
- a final code staying put;
- a busy start never producing a second pre-load strobe.

The bench scenarios show what needs a whole load to judge: the exact bit order over multi-byte streams with and without gaps, how many bytes get through before an injected integrity error at the first or a later byte, each timeout firing after the configured span, a zero-length load, and a repeat start during a load changing nothing.

// File: rtl/sercfg_pkg.sv
`timescale 1ns/1ps
package sercfg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_BUSY     = 3'd1,
      ST_OK       = 3'd2,
      ST_INIT_TMO = 3'd3,
      ST_CRC_ERR  = 3'd4,
      ST_DONE_TMO = 3'd5
   } cfg_status_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CLEAR,
      PH_RELEASE,
      PH_FETCH,
      PH_SHIFT,
      PH_FINISH
   } cfg_phase_e;

endpackage

// File: rtl/sercfg_tick.sv
`timescale 1ns/1ps
// Half-period strobe generator for the serial clock.
module sercfg_tick #(
   parameter int unsigned DIV = 2
)(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic tick_o
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 1) begin : g_bad_div
      $error("sercfg_tick: DIV must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (!en_i)          cnt_q <= '0;
      else if (cnt_q == LAST)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + CW'(1);
   end

   assign tick_o = en_i && (cnt_q == LAST);

   AST_TICK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST) else $error("tick counter out of range"); // R5

   AST_TICK_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (cnt_q == '0)) else $error("tick counter not cleared"); // R5
endmodule

// File: rtl/sercfg_timer.sv
`timescale 1ns/1ps
// Saturating wait-phase timeout counter.
module sercfg_timer #(
   parameter int unsigned LIMIT = 1000
)(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic clr_i,
   output logic expired_o
);
   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("sercfg_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cnt_q <= '0;
      else if (clr_i)               cnt_q <= '0;
      else if (en_i && !expired_o)  cnt_q <= cnt_q + CW'(1);
   end

   assign expired_o = (cnt_q == LAST);

   AST_TMR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0)) else $error("timer not cleared"); // R3

   AST_TMR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST) else $error("timer past limit"); // R3
endmodule

// File: rtl/sercfg_shift.sv
`timescale 1ns/1ps
// MSB-first parallel-to-serial byte register.
module sercfg_shift #(
   parameter int unsigned W = 8
)(
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] data_i,
   input  logic         shift_i,
   output logic         msb_o,
   output logic         last_o
);
   localparam int unsigned BCW = (W > 1) ? $clog2(W) : 1;
   localparam logic [BCW-1:0] LAST = BCW'(W - 1);

   if (W < 2) begin : g_bad_width
      $error("sercfg_shift: W must be at least 2");
   end

   logic [W-1:0]   sh_q;
   logic [BCW-1:0] bit_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q  <= '0;
         bit_q <= '0;
      end else if (load_i) begin
         sh_q  <= data_i;
         bit_q <= '0;
      end else if (shift_i) begin
         sh_q  <= {sh_q[W-2:0], 1'b0};
         bit_q <= bit_q + BCW'(1);
      end
   end

   assign msb_o  = sh_q[W-1];
   assign last_o = (bit_q == LAST);

   AST_SHIFT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (bit_q == '0) && (msb_o == $past(data_i[W-1])))
      else $error("load did not present top bit"); // R4
endmodule

// File: rtl/sercfg_loader.sv
`timescale 1ns/1ps
// Slave-serial configuration sequencer for a target FPGA.
module sercfg_loader
   import sercfg_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned TIMEOUT_CYC = 1000000,
   parameter int unsigned CCLK_DIV    = 2
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  byte_count_i,
   input  logic [DATA_W-1:0] s_data_i,
   input  logic              s_valid_i,
   output logic              s_ready_o,
   output logic              tgt_clear_n_o,
   output logic              ser_clk_o,
   output logic              ser_dat_o,
   input  logic              tgt_busy_n_i,
   input  logic              tgt_live_i,
   output logic              pre_hook_o,
   output logic              post_hook_o,
   output logic [2:0]        status_o
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("sercfg_loader: CNT_W must be at least 1");
   end

   cfg_phase_e       st_q, st_n;
   cfg_status_e      status_q, fin_code;
   logic [CNT_W-1:0] left_q;
   logic             sclk_q, pre_q, post_q;
   logic             fin, tick, tmo, accept, err_seen, shift_bit, last_bit, msb;
   logic             tick_en, tmr_en, tmr_clr;

   assign err_seen  = !tgt_busy_n_i && !tgt_live_i;
   assign s_ready_o = (st_q == PH_FETCH) && (left_q != '0) && !err_seen;
   assign accept    = s_ready_o && s_valid_i;
   assign tick_en   = (st_q == PH_SHIFT) || (st_q == PH_FINISH);
   assign tmr_en    = (st_q == PH_CLEAR) || (st_q == PH_RELEASE) || (st_q == PH_FINISH);
   assign tmr_clr   = (st_n != st_q);
   assign shift_bit = (st_q == PH_SHIFT) && tick && sclk_q;

   sercfg_tick #(.DIV(CCLK_DIV)) u_tick (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tick_en), .tick_o(tick));

   sercfg_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tmr_en), .clr_i(tmr_clr), .expired_o(tmo));

   sercfg_shift #(.W(DATA_W)) u_shift (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .data_i(s_data_i),
      .shift_i(shift_bit), .msb_o(msb), .last_o(last_bit));

   always_comb begin
      st_n     = st_q;
      fin      = 1'b0;
      fin_code = ST_OK;
      unique case (st_q)
         PH_IDLE:    if (start_i) st_n = PH_CLEAR;
         PH_CLEAR:   if (!tgt_busy_n_i) st_n = PH_RELEASE;
                     else if (tmo) begin fin = 1'b1; fin_code = ST_INIT_TMO; end
         PH_RELEASE: if (tgt_busy_n_i) st_n = PH_FETCH;
                     else if (tmo) begin fin = 1'b1; fin_code = ST_INIT_TMO; end
         PH_FETCH:   if (left_q == '0) st_n = PH_FINISH;
                     else if (err_seen) begin fin = 1'b1; fin_code = ST_CRC_ERR; end
                     else if (s_valid_i) st_n = PH_SHIFT;
         PH_SHIFT:   if (shift_bit && last_bit) st_n = PH_FETCH;
         PH_FINISH:  if (tgt_live_i) begin fin = 1'b1; fin_code = ST_OK; end
                     else if (tmo) begin fin = 1'b1; fin_code = ST_DONE_TMO; end
         default:    st_n = PH_IDLE;
      endcase
      if (fin) st_n = PH_IDLE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= PH_IDLE;
         status_q <= ST_IDLE;
         left_q   <= '0;
         sclk_q   <= 1'b0;
         pre_q    <= 1'b0;
         post_q   <= 1'b0;
      end else begin
         st_q   <= st_n;
         pre_q  <= (st_q == PH_IDLE) && start_i;
         post_q <= fin;
         if ((st_q == PH_IDLE) && start_i) begin
            left_q   <= byte_count_i;
            status_q <= ST_BUSY;
         end
         if (accept) left_q <= left_q - CNT_W'(1);
         if (tick_en && tick) sclk_q <= !sclk_q;
         if (fin) begin
            sclk_q   <= 1'b0;
            status_q <= fin_code;
         end
      end
   end

   assign tgt_clear_n_o = (st_q != PH_CLEAR);
   assign ser_clk_o     = sclk_q;
   assign ser_dat_o     = (st_q == PH_SHIFT) ? msb : 1'b1;
   assign pre_hook_o    = pre_q;
   assign post_hook_o   = post_q;
   assign status_o      = status_q;

   AST_DAT_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_dat_o))
      else $error("data moved while serial clock high"); // R5

   AST_QUIET_IN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tgt_clear_n_o |-> (!ser_clk_o && !s_ready_o))
      else $error("activity while clear asserted"); // R1

   AST_NO_TAKE_ON_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s_ready_o |-> (tgt_busy_n_i || tgt_live_i))
      else $error("byte offered during target error"); // R6

   AST_READY_CLOCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s_ready_o |-> !ser_clk_o) else $error("ready during shifting"); // R10

   AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((status_q == ST_BUSY) && start_i) |=> !pre_hook_o)
      else $error("restart during load"); // R11

   AST_POST_FINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      post_hook_o |-> ((status_q != ST_BUSY) && (status_q != ST_IDLE)))
      else $error("post strobe without final code"); // R8

   AST_HOOKS_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({pre_hook_o, post_hook_o})) else $error("strobes overlap"); // R8

   AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((status_q != ST_BUSY) && (status_q != ST_IDLE) && !start_i) |=> $stable(status_q))
      else $error("final code changed"); // R9
endmodule

// File: tb/sercfg_loader_tb_top.sv
`timescale 1ns/1ps
module sercfg_loader_tb_top;
   localparam int DW = 8;
   localparam int CW = 16;
   localparam int TMO = 300;
   localparam int DIV = 2;
   localparam int DONE_EDGES = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          start = 1'b0;
   logic [CW-1:0] bcount = '0;
   logic [DW-1:0] sdata = '0;
   logic          svalid = 1'b0;
   logic          busy_n = 1'b1, live = 1'b0;
   wire           sready, clear_n, sclk, sdat, pre, post;
   wire [2:0]     status;

   sercfg_loader #(.DATA_W(DW), .CNT_W(CW), .TIMEOUT_CYC(TMO), .CCLK_DIV(DIV)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_count_i(bcount),
      .s_data_i(sdata), .s_valid_i(svalid), .s_ready_o(sready),
      .tgt_clear_n_o(clear_n), .ser_clk_o(sclk), .ser_dat_o(sdat),
      .tgt_busy_n_i(busy_n), .tgt_live_i(live),
      .pre_hook_o(pre), .post_hook_o(post), .status_o(status));

   int  n_checks = 0, n_fail = 0;
   bit  exp_q[$];
   bit  mon_b;
   int  bits_seen = 0, extra_edges = 0, total_edges = 0, accepted = 0;
   int  pre_cnt = 0, post_cnt = 0, clear_cyc = 0, cyc = 0, end_cyc = 0, tot_bits = 0;
   time last_t = 0;
   bit  m_no_init_low = 0, m_stuck_low = 0, m_no_done = 0, crc_flag = 0;
   int  m_crc_byte = -1, prog_cnt = 0, rel_cnt = 0;
   logic [DW-1:0] pat [6];

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #2;
      cyc++;
   endtask

   // Scoreboard monitor: compare each rising serial edge with the queue
   always @(posedge sclk) begin
      #1;
      total_edges++;
      if (exp_q.size() > 0) begin
         mon_b = exp_q.pop_front();
         if (bits_seen % DW != 0)
            chk(($time - last_t) == 2 * DIV * 10, "R5 half-period", longint'($time - last_t), 2 * DIV * 10);
         chk(sdat == mon_b, "R4 bit order", sdat, mon_b);
         chk(busy_n == 1'b1, "R2 data only after status high", busy_n, 1);
         bits_seen++;
      end else begin
         chk(sdat == 1'b1, "R7 line high after data", sdat, 1);
         extra_edges++;
      end
      last_t = $time;
   end

   always @(negedge clk) begin
      if (pre) pre_cnt++;
      if (post) post_cnt++;
      if (!clear_n) clear_cyc++;
   end

   // Target model, driven away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         busy_n = 1'b1; live = 1'b0; prog_cnt = 0; rel_cnt = 0; crc_flag = 0;
      end else if (!clear_n) begin
         crc_flag = 0; live = 1'b0; rel_cnt = 0; prog_cnt++;
         if (m_no_init_low) busy_n = 1'b1;
         else if (prog_cnt >= 3) busy_n = 1'b0;
      end else begin
         prog_cnt = 0;
         if (!busy_n && !crc_flag) begin
            if (!m_stuck_low) begin
               rel_cnt++;
               if (rel_cnt >= 4) busy_n = 1'b1;
            end
         end else if (busy_n && status == 3'd1 && m_crc_byte >= 0 &&
                      bits_seen == DW * m_crc_byte && !crc_flag) begin
            crc_flag = 1; busy_n = 1'b0;
         end
         if (!m_no_done && status == 3'd1 && bits_seen == tot_bits &&
             exp_q.size() == 0 && extra_edges >= DONE_EDGES)
            live = 1'b1;
      end
   end

   // Driver: offer one byte, push its bits when the handshake completes
   task automatic send_byte(input logic [DW-1:0] b);
      sdata = b; svalid = 1'b1;
      while (!sready) begin
         if (status != 3'd1) begin svalid = 1'b0; return; end
         step();
      end
      step();
      accepted++;
      for (int k = DW - 1; k >= 0; k--) exp_q.push_back(b[k]);
      chk(sready == 1'b0, "R10 ready low while shifting", sready, 0);
      svalid = 1'b0;
   endtask

   task automatic run_load(input int n, input int gap, input bit dbl);
      int c0;
      exp_q.delete();
      bits_seen = 0; extra_edges = 0; total_edges = 0; accepted = 0;
      pre_cnt = 0; post_cnt = 0; clear_cyc = 0; tot_bits = n * DW;
      start = 1'b1; bcount = CW'(n);
      step();
      start = 1'b0;
      c0 = cyc;
      chk(clear_n == 1'b0, "R1 clear low after start", clear_n, 0);
      for (int i = 0; i < n; i++) begin
         if (status != 3'd1) break;
         send_byte(pat[i]);
         if (dbl && i == 0) begin
            start = 1'b1; bcount = CW'(1);
            step();
            start = 1'b0;
         end
         repeat (gap) step();
      end
      while (status == 3'd1 && (cyc - c0) < 20000) step();
      end_cyc = cyc - c0;
      step();
   endtask

   initial begin
      pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'h01; pat[3] = 8'h80; pat[4] = 8'hFF; pat[5] = 8'h00;
      repeat (5) step();
      chk(status == 3'd0, "R9 reset status", status, 0);
      chk(clear_n == 1'b1, "R1 reset clear high", clear_n, 1);
      chk(sclk == 1'b0, "R5 reset clock low", sclk, 0);
      chk(sready == 1'b0, "R10 reset ready low", sready, 0);
      chk(sdat == 1'b1, "R7 reset data high", sdat, 1);
      rst_n = 1'b1;
      step();

      // Four bytes back to back
      run_load(4, 0, 0);
      chk(status == 3'd2, "R7 success", status, 2);
      chk(bits_seen == 32, "R4 bit count", bits_seen, 32);
      chk(extra_edges >= DONE_EDGES, "R7 trailing clocks", extra_edges, DONE_EDGES);
      chk(pre_cnt == 1, "R1 pre strobe", pre_cnt, 1);
      chk(post_cnt == 1, "R8 post strobe on success", post_cnt, 1);
      repeat (30) step();
      chk(status == 3'd2, "R9 result holds", status, 2);

      // Gapped stream with a repeated start during the load
      pat[0] = 8'hFF; pat[1] = 8'h00; pat[2] = 8'h5A;
      run_load(3, 5, 1);
      chk(status == 3'd2, "R11 load unaffected", status, 2);
      chk(pre_cnt == 1, "R11 no second pre strobe", pre_cnt, 1);
      chk(accepted == 3, "R11 count not reloaded", accepted, 3);
      chk(bits_seen == 24, "R4 gapped bits", bits_seen, 24);

      // Zero-length load
      run_load(0, 0, 0);
      chk(status == 3'd2, "R12 zero count success", status, 2);
      chk(accepted == 0, "R12 no byte taken", accepted, 0);
      chk(extra_edges >= DONE_EDGES, "R12 trailing clocks", extra_edges, DONE_EDGES);

      // Integrity error before the third byte
      pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'h01; pat[3] = 8'h80;
      m_crc_byte = 2;
      run_load(4, 0, 0);
      chk(status == 3'd4, "R6 error status", status, 4);
      chk(accepted == 2, "R6 bytes before error", accepted, 2);
      chk(bits_seen == 16, "R6 bits before error", bits_seen, 16);
      chk(post_cnt == 1, "R8 post strobe on error", post_cnt, 1);
      begin
         int te;
         te = total_edges;
         repeat (20) step();
         chk(total_edges == te, "R6 clock stops", total_edges, te);
      end

      // Integrity error before the first byte
      m_crc_byte = 0;
      run_load(2, 0, 0);
      chk(status == 3'd4, "R6 error at first byte", status, 4);
      chk(accepted == 0, "R6 nothing taken", accepted, 0);
      m_crc_byte = -1;

      // Status line never drops
      m_no_init_low = 1;
      run_load(2, 0, 0);
      chk(status == 3'd3, "R3 first wait timeout", status, 3);
      chk(end_cyc >= TMO - 2 && end_cyc <= TMO + 10, "R3 timeout span", end_cyc, TMO);
      chk(clear_cyc >= TMO - 2, "R1 clear held through wait", clear_cyc, TMO);
      chk(clear_n == 1'b1, "R1 clear released after fail", clear_n, 1);
      chk(total_edges == 0, "R2 no clock on timeout", total_edges, 0);
      chk(post_cnt == 1, "R8 post strobe on timeout", post_cnt, 1);
      m_no_init_low = 0;

      // Status line never returns high
      m_stuck_low = 1;
      run_load(2, 0, 0);
      chk(status == 3'd3, "R3 second wait timeout", status, 3);
      chk(total_edges == 0, "R2 no clock while status low", total_edges, 0);
      chk(accepted == 0, "R2 no byte while status low", accepted, 0);
      m_stuck_low = 0;

      // Target never signals running
      m_no_done = 1;
      run_load(2, 0, 0);
      chk(status == 3'd5, "R3 final wait timeout", status, 5);
      chk(bits_seen == 16, "R4 bits before final wait", bits_seen, 16);
      chk(extra_edges >= 10, "R7 clocks during final wait", extra_edges, 10);
      chk(post_cnt == 1, "R8 post strobe on final timeout", post_cnt, 1);
      m_no_done = 0;
      repeat (30) step();
      chk(status == 3'd5, "R9 failure code holds", status, 5);

      // Recovery after failures
      run_load(1, 0, 0);
      chk(status == 3'd2, "R9 new start replaces code", status, 2);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule